// File: doc/BRIEF.md
# Way-Memoizing Set-Associative Instruction Cache

This block is a small four-way set-associative instruction cache for a fetch stage that issues one request at a time, in order. To save energy it remembers where lines were found. Each resident line has a pointer, with its own valid bit, to the way that holds the next sequential line. A small table, indexed by branch target line address, holds the way of each redirect target. A fetch that can use a valid pointer skips tag comparison and enables one data way. Fetches that stay inside the line fetched last use its way directly. A memoized hit takes the same one cycle as a hit found by a full tag check.

Without a usable pointer, all four tags are compared in parallel. A hit found this way, or a line brought in by refill, is written into the pointer slot that led to the fetch: the previous line's sequential link, or the target table entry. On a miss a whole line is fetched through a simple request/valid refill port. The victim is an invalid way if one exists, and otherwise the way chosen by a three-bit tree pseudo-LRU for the set. In the refill cycle every sequential link in the preceding set and every target entry that names the victim's set and way is cleared. Two counters report full tag lookups and single-way accesses.

Top module: `wmic_top`

## Requirements
- R1: After reset, fetchReady is 1, respValid is 0, refillReq is 0 and both counters are 0.
- R2: Every response carries the memory word at the requested word address, including after evictions of lines that stored pointers name. Word address = {line, offset}, offset in the low 2 bits, set index in the next 2 bits, and target table index in the 2 bits above those.
- R3: A hit of either kind raises respValid in the cycle after acceptance. A miss raises refillReq with the line address in the cycle after acceptance, holds it until refillValid, and gives the response in the cycle after refillValid.
- R4: A non-redirect fetch into the same line as the previous fetch is a single-way access with no refill.
- R5: A non-redirect fetch into line L+1 after line L does a full lookup the first time and is a single-way access afterwards, while both lines stay resident.
- R6: A redirect fetch does a full lookup when its target table entry does not name its line, and is a single-way access when the entry recorded by an earlier lookup or refill is still valid.
- R7: Each accepted fetch increments exactly one of cntFull (full lookup) and cntMemo (single-way access), and a single-way access never requests a refill.
- R8: Refilling the line that a sequential link points to clears that link, so the next crossing does a full lookup and refills.
- R9: Refilling the line that a target table entry points to clears that entry, so the next redirect to the old target does a full lookup and refills.
- R10: When a refill clears links and also records a new pointer in the same cycle, the new pointer stays valid.
- R11: An invalid way is filled first; with all ways valid the tree pseudo-LRU victim is replaced, so the fourth new line into a full set evicts the least recently used way and leaves the others resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetch request present |
| fetchRedir | input | 1 | Request is a branch redirect target |
| fetchAddr | input | ADDR_W | Word address to fetch |
| fetchReady | output | 1 | Cache can accept a request |
| respValid | output | 1 | Fetched word valid |
| respData | output | DATA_W | Fetched word |
| refillReq | output | 1 | Line refill requested |
| refillAddr | output | ADDR_W-OFF_W | Line address to refill |
| refillValid | input | 1 | Refill line present |
| refillData | input | DATA_W*2^OFF_W | Whole refill line, word 0 in the low bits |
| cntFull | output | CNT_W | Full tag lookups |
| cntMemo | output | CNT_W | Single-way accesses |

## Verification
The refill of a sequential or redirect miss clears pointers that name the victim and writes the new pointer in the same cycle. When a sequential fetch misses, both touch the previous line's link. A directed sequence misses on a line crossing and then crosses again. The second crossing must count as a single-way access, and random runs with constant evictions must return the reference word on every fetch, which shows that clearing never leaves a stale pointer behind.

// File: rtl/wmic_pkg.sv
package wmic_pkg;

  typedef struct packed {
    logic lookup;
    logic fill;
  } wmicCtrlT;

  typedef enum logic [1:0] {SRC_NONE, SRC_SAME, SRC_LINK, SRC_TGT} wmicSrcT;

  typedef enum logic {ST_IDLE, ST_FILL} wmicStateT;

  function automatic logic [1:0] plruVictim(input logic [3:0] vld, input logic [2:0] p);
    logic [1:0] v;
    if (!vld[0]) v = 2'd0;
    else if (!vld[1]) v = 2'd1;
    else if (!vld[2]) v = 2'd2;
    else if (!vld[3]) v = 2'd3;
    else v = p[0] ? (p[2] ? 2'd3 : 2'd2) : (p[1] ? 2'd1 : 2'd0);
    return v;
  endfunction

  function automatic logic [2:0] plruTouch(input logic [2:0] p, input logic [1:0] w);
    logic [2:0] n;
    n = p;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = (w == 2'd0);
    end else begin
      n[0] = 1'b0;
      n[2] = (w == 2'd2);
    end
    return n;
  endfunction

endpackage

// File: rtl/wmic_ctrl.sv
module wmic_ctrl
  import wmic_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fetchValid,
  input  logic     miss,
  input  logic     refillValid,
  output logic     fetchReady,
  output logic     refillReq,
  output wmicCtrlT ctl
);

  wmicStateT state;

  assign fetchReady = (state == ST_IDLE);
  assign refillReq  = (state == ST_FILL);
  assign ctl.lookup = fetchReady && fetchValid;
  assign ctl.fill   = refillReq && refillValid;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else if (ctl.lookup && miss) state <= ST_FILL;
    else if (ctl.fill) state <= ST_IDLE;
  end

  AST_MISS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fetchValid && fetchReady && miss |=> refillReq); // R3
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    refillReq && !refillValid |=> refillReq && !fetchReady); // R3

endmodule

// File: rtl/wmic_datapath.sv
module wmic_datapath
  import wmic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 2,
  parameter int SET_W  = 2,
  parameter int TGT_W  = 2,
  parameter int CNT_W  = 16,
  localparam int WORDS = 1 << OFF_W,
  localparam int SETS  = 1 << SET_W,
  localparam int TGTN  = 1 << TGT_W,
  localparam int LA_W  = ADDR_W - OFF_W,
  localparam int TAG_W = LA_W - SET_W,
  localparam int LINE_BITS = WORDS * DATA_W
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  wmicCtrlT             ctl,
  input  logic                 fetchRedir,
  input  logic [ADDR_W-1:0]    fetchAddr,
  output logic                 miss,
  output logic                 respValid,
  output logic [DATA_W-1:0]    respData,
  output logic [LA_W-1:0]      refillAddr,
  input  logic [LINE_BITS-1:0] refillData,
  output logic [CNT_W-1:0]     cntFull,
  output logic [CNT_W-1:0]     cntMemo
);

  logic [TAG_W-1:0]     tagArr  [SETS][4];
  logic [LINE_BITS-1:0] dataArr [SETS][4];
  logic [3:0]           vldArr  [SETS];
  logic [3:0]           linkVld [SETS];
  logic [1:0]           linkWay [SETS][4];
  logic [2:0]           plru    [SETS];
  logic [LA_W-1:0]      tgtLine [TGTN];
  logic [1:0]           tgtWay  [TGTN];
  logic [TGTN-1:0]      tgtVld;

  logic [LA_W-1:0]   prevLine;
  logic [1:0]        prevWay;
  logic              prevVld;
  logic [ADDR_W-1:0] curAddr;
  wmicSrcT           curRec;
  logic [1:0]        curWay;

  logic [LA_W-1:0]  inLine;
  logic [SET_W-1:0] inSet, prevSet, curSet, linkSet;
  logic [TAG_W-1:0] inTag;
  logic [OFF_W-1:0] inOff, curOff;
  logic [TGT_W-1:0] inTgt, curTgt;
  logic             memo;
  logic [1:0]       memoWay, hitWay, useWay, victim;
  logic [3:0]       hitVec;
  wmicSrcT          rec;

  assign inLine  = fetchAddr[ADDR_W-1:OFF_W];
  assign inSet   = inLine[SET_W-1:0];
  assign inTag   = inLine[LA_W-1:SET_W];
  assign inOff   = fetchAddr[OFF_W-1:0];
  assign inTgt   = inLine[SET_W +: TGT_W];
  assign prevSet = prevLine[SET_W-1:0];
  assign curSet  = curAddr[OFF_W +: SET_W];
  assign curOff  = curAddr[OFF_W-1:0];
  assign curTgt  = curAddr[OFF_W+SET_W +: TGT_W];
  assign linkSet = curSet - 1'b1;
  assign refillAddr = curAddr[ADDR_W-1:OFF_W];

  always_comb begin
    memo = 1'b0;
    memoWay = 2'd0;
    rec = SRC_NONE;
    if (fetchRedir) begin
      if (tgtVld[inTgt] && tgtLine[inTgt] == inLine) begin
        memo = 1'b1;
        memoWay = tgtWay[inTgt];
      end else rec = SRC_TGT;
    end else if (prevVld && inLine == prevLine) begin
      memo = 1'b1;
      memoWay = prevWay;
      rec = SRC_SAME;
    end else if (prevVld && inLine == prevLine + 1'b1) begin
      if (linkVld[prevSet][prevWay]) begin
        memo = 1'b1;
        memoWay = linkWay[prevSet][prevWay];
      end else rec = SRC_LINK;
    end
    hitWay = 2'd0;
    for (int w = 0; w < 4; w++) begin
      hitVec[w] = vldArr[inSet][w] && tagArr[inSet][w] == inTag;
      if (hitVec[w]) hitWay = w[1:0];
    end
    miss   = !memo && hitVec == 4'd0;
    useWay = memo ? memoWay : hitWay;
    victim = plruVictim(vldArr[inSet], plru[inSet]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vldArr[s]  <= '0;
        linkVld[s] <= '0;
        plru[s]    <= '0;
      end
      tgtVld    <= '0;
      prevVld   <= 1'b0;
      respValid <= 1'b0;
      cntFull   <= '0;
      cntMemo   <= '0;
      curRec    <= SRC_NONE;
      curWay    <= 2'd0;
      curAddr   <= '0;
    end else begin
      respValid <= (ctl.lookup && !miss) || ctl.fill;
      if (ctl.lookup) begin
        if (memo) cntMemo <= cntMemo + 1'b1;
        else cntFull <= cntFull + 1'b1;
        if (miss) begin
          curAddr <= fetchAddr;
          curRec  <= rec;
          curWay  <= victim;
        end else begin
          plru[inSet] <= plruTouch(plru[inSet], useWay);
          prevLine <= inLine;
          prevWay  <= useWay;
          prevVld  <= 1'b1;
          if (!memo && rec == SRC_LINK) begin
            linkVld[prevSet][prevWay] <= 1'b1;
            linkWay[prevSet][prevWay] <= hitWay;
          end
          if (!memo && rec == SRC_TGT) begin
            tgtVld[inTgt]  <= 1'b1;
            tgtLine[inTgt] <= inLine;
            tgtWay[inTgt]  <= hitWay;
          end
        end
      end
      if (ctl.fill) begin
        // clear every pointer naming the victim first; the record below wins
        for (int w = 0; w < 4; w++)
          if (linkWay[linkSet][w] == curWay) linkVld[linkSet][w] <= 1'b0;
        for (int b = 0; b < TGTN; b++)
          if (tgtLine[b][SET_W-1:0] == curSet && tgtWay[b] == curWay) tgtVld[b] <= 1'b0;
        linkVld[curSet][curWay] <= 1'b0;
        vldArr[curSet][curWay]  <= 1'b1;
        plru[curSet] <= plruTouch(plru[curSet], curWay);
        if (curRec == SRC_LINK) begin
          linkVld[prevSet][prevWay] <= 1'b1;
          linkWay[prevSet][prevWay] <= curWay;
        end
        if (curRec == SRC_TGT) begin
          tgtVld[curTgt]  <= 1'b1;
          tgtLine[curTgt] <= curAddr[ADDR_W-1:OFF_W];
          tgtWay[curTgt]  <= curWay;
        end
        prevLine <= curAddr[ADDR_W-1:OFF_W];
        prevWay  <= curWay;
        prevVld  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.fill) begin
      tagArr[curSet][curWay]  <= curAddr[ADDR_W-1:OFF_W+SET_W];
      dataArr[curSet][curWay] <= refillData;
    end
    if (ctl.lookup) respData <= dataArr[inSet][useWay][inOff*DATA_W +: DATA_W];
    else if (ctl.fill) respData <= refillData[curOff*DATA_W +: DATA_W];
  end

  AST_MEMO_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.lookup && memo |-> vldArr[inSet][memoWay] && tagArr[inSet][memoWay] == inTag); // R2
  AST_ONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.lookup |=> (cntFull != $past(cntFull)) != (cntMemo != $past(cntMemo))); // R7
  AST_RECORD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.fill && curRec == SRC_LINK |=> linkVld[$past(prevSet)][$past(prevWay)]); // R10

endmodule

// File: rtl/wmic_top.sv
module wmic_top
  import wmic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 2,
  parameter int SET_W  = 2,
  parameter int TGT_W  = 2,
  parameter int CNT_W  = 16
)(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             fetchValid,
  input  logic                             fetchRedir,
  input  logic [ADDR_W-1:0]                fetchAddr,
  output logic                             fetchReady,
  output logic                             respValid,
  output logic [DATA_W-1:0]                respData,
  output logic                             refillReq,
  output logic [ADDR_W-OFF_W-1:0]          refillAddr,
  input  logic                             refillValid,
  input  logic [DATA_W*(1<<OFF_W)-1:0]     refillData,
  output logic [CNT_W-1:0]                 cntFull,
  output logic [CNT_W-1:0]                 cntMemo
);

  wmicCtrlT ctl;
  logic     miss;

  wmic_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .fetchValid(fetchValid), .miss(miss),
    .refillValid(refillValid), .fetchReady(fetchReady), .refillReq(refillReq), .ctl(ctl)
  );

  wmic_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
    .SET_W(SET_W), .TGT_W(TGT_W), .CNT_W(CNT_W)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .fetchRedir(fetchRedir), .fetchAddr(fetchAddr),
    .miss(miss), .respValid(respValid), .respData(respData), .refillAddr(refillAddr),
    .refillData(refillData), .cntFull(cntFull), .cntMemo(cntMemo)
  );

  AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    fetchValid && fetchReady && !miss |=> respValid); // R3
  AST_FILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    refillReq && refillValid |=> respValid && !refillReq); // R3

endmodule

// File: tb/test_wmic_top.sv
module test_wmic_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int OFF_W  = 2;
  localparam int CNT_W  = 16;
  localparam int LINE_BITS = DATA_W * (1 << OFF_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetchValid = 1'b0, fetchRedir = 1'b0;
  logic [ADDR_W-1:0] fetchAddr = '0;
  logic fetchReady, respValid, refillReq;
  logic [DATA_W-1:0] respData;
  logic [ADDR_W-OFF_W-1:0] refillAddr;
  logic refillValid = 1'b0;
  logic [LINE_BITS-1:0] refillData = '0;
  logic [CNT_W-1:0] cntFull, cntMemo;

  int nTests = 0, nFail = 0, cycles = 0, delay = 0;
  bit sawRefill = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wmic_top i_wmic_top (
    .clk(clk), .rst_n(rst_n), .fetchValid(fetchValid), .fetchRedir(fetchRedir),
    .fetchAddr(fetchAddr), .fetchReady(fetchReady), .respValid(respValid),
    .respData(respData), .refillReq(refillReq), .refillAddr(refillAddr),
    .refillValid(refillValid), .refillData(refillData), .cntFull(cntFull), .cntMemo(cntMemo)
  );

  function automatic logic [DATA_W-1:0] memWord(input int a);
    return (a * 32'h9E3779B1) ^ 32'hC3A50F1E ^ (a << 7);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  // refill responder: whole line after 0..2 idle cycles
  initial begin
    forever begin
      @(negedge clk);
      if (refillValid) refillValid = 1'b0;
      else if (refillReq) begin
        if (delay == 0) begin
          for (int k = 0; k < (1 << OFF_W); k++)
            refillData[k*DATA_W +: DATA_W] = memWord(int'(refillAddr) * (1 << OFF_W) + k);
          refillValid = 1'b1;
          sawRefill = 1;
          delay = $urandom % 3;
        end else delay--;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nTests++; nFail++;
        $display("FAIL watchdog expired");
        finishRun();
      end
    end
  end

  // one fetch; returns memo/full increments and whether a refill happened
  task automatic doFetch(input int addr, input bit redir, output bit memoInc,
                         output bit fullInc, output bit refilled, output bit hitLat);
    logic [CNT_W-1:0] f0, m0;
    int waitN;
    @(negedge clk);
    while (!fetchReady) @(negedge clk);
    f0 = cntFull; m0 = cntMemo;
    sawRefill = 0;
    fetchValid = 1'b1; fetchRedir = redir; fetchAddr = addr[ADDR_W-1:0];
    @(negedge clk);
    fetchValid = 1'b0;
    hitLat = respValid;
    waitN = 0;
    while (!respValid && waitN < 50) begin @(negedge clk); waitN++; end
    check(respValid, "R3 response arrives", respValid, 1);
    check(respData == memWord(addr), "R2 data", respData, memWord(addr));
    memoInc = (cntMemo != m0);
    fullInc = (cntFull != f0);
    refilled = sawRefill;
    check(memoInc != fullInc, "R7 one counter", {memoInc, fullInc}, 2'b01);
    check(!(memoInc && refilled), "R7 memo without refill", refilled, 0);
  endtask

  task automatic expectStep(input int addr, input bit redir, input bit expMemo,
                            input bit expRefill, input string req);
    bit m, f, r, h;
    doFetch(addr, redir, m, f, r, h);
    check(m == expMemo, req, m, expMemo);
    check(r == expRefill, req, r, expRefill);
    check(h == !expRefill, "R3 hit latency", h, !expRefill);
  endtask

  initial begin
    bit m, f, r, h;
    int a;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(fetchReady && !respValid && !refillReq, "R1 reset handshake",
          {fetchReady, respValid, refillReq}, 3'b100);
    check(cntFull == 0 && cntMemo == 0, "R1 reset counters", {cntFull, cntMemo}, 0);

    expectStep(0, 1, 0, 1, "R6 first redirect full");
    expectStep(1, 0, 1, 0, "R4 same line memo");
    expectStep(4, 0, 0, 1, "R5 first crossing full");
    expectStep(5, 0, 1, 0, "R4 same line memo");
    expectStep(0, 1, 1, 0, "R6 repeat redirect memo");
    expectStep(4, 0, 1, 0, "R10 link recorded during refill");
    // fill set 1: lines 5, 9, 13, 21; the fourth evicts line 1 (way 0)
    expectStep(20, 1, 0, 1, "R11 fill invalid way");
    expectStep(36, 1, 0, 1, "R11 fill invalid way");
    expectStep(52, 1, 0, 1, "R11 fill invalid way");
    expectStep(84, 1, 0, 1, "R11 replace plru way");
    expectStep(0, 1, 1, 0, "R6 unrelated entry kept");
    expectStep(4, 0, 0, 1, "R8 link cleared on replace");
    expectStep(20, 1, 0, 0, "R11 other way still resident");
    // fill set 0: lines 4, 8, 12, 20; the fourth evicts line 0
    expectStep(16, 1, 0, 1, "R11 fill set 0");
    expectStep(32, 1, 0, 1, "R11 fill set 0");
    expectStep(48, 1, 0, 1, "R11 fill set 0");
    expectStep(80, 1, 0, 1, "R11 replace in set 0");
    expectStep(0, 1, 0, 1, "R9 target entry cleared on replace");
    expectStep(0, 1, 1, 0, "R6 entry recorded during refill");

    a = 0;
    for (int i = 0; i < 400; i++) begin
      bit redir;
      redir = ($urandom % 10) < 4;
      if (redir) a = $urandom % 128;
      else a = (a + 1) % 4096;
      doFetch(a, redir, m, f, r, h);
    end
    finishRun();
  end
endmodule